// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Per-Line Edge/Level Configuration

This block gathers interrupt requests from three banks of 32 lines each. One bank belongs to the main controller and the other two belong to subordinate controllers. Every line can be set up on its own, in one of four ways:

- sensitive to a level or to an edge;
- active high / rising, or active low / falling.

Each line also has a mask bit and a choice of whether it routes to the normal request output or the fast request output. Software reaches all of these settings through a single-cycle register port. A 2-bit select picks the controller and a byte offset picks the register. Reads are combinational.

Each subordinate controller produces a normal request and a fast request. These four signals feed fixed lines of the main controller:

| Source | Main line |
|---|---|
| Sub 1 normal request | 0 |
| Sub 2 normal request | 1 |
| Sub 2 fast request | 30 |
| Sub 1 fast request | 31 |

The external inputs at those four main positions are not used. After reset, only the four cascade lines of the main controller are unmasked. The main controller drives the processor's `irq_o` and `fiq_o`.

A handler acknowledges an edge interrupt in two steps. It first clears the line's mask bit. It then writes a one to that line's status bit.

Top module: `icc_top`

## Requirements
- R1: After reset the main enable register reads 0xC0000003, both subordinate enable registers read 0, all status registers read 0, all polarity bits are 1, all type bits are 0, the main route register reads 0xC0000000, and `irq_o`/`fiq_o` are low.
- R2: Register offset 0x00 holds the enable bits. A 1 unmasks a line and a 0 masks it. A masked line never contributes to its controller's outputs.
- R3: Offset 0x10 is the type register, where a 1 selects edge mode. Offset 0x0C is the polarity register, where a 1 selects rising/high and a 0 selects falling/low. In edge mode a status bit (offset 0x08) sets on the selected edge of the synchronized input and stays set until cleared.
- R4: Writing a 1 to a bit at offset 0x08 clears an edge-latched status bit. Writing a 0 leaves it unchanged. An edge that arrives in the same cycle as a clear wins.
- R5: In level mode a status bit is the polarity-corrected input, registered once. Writes to the status register do not affect it.
- R6: Offset 0x04 is read-only. It shows the polarity-corrected synchronized input of every line, whether or not the line is masked.
- R7: Each external input passes through two flip-flops. A change appears at offset 0x04 after the second clock edge and in the status after the third.
- R8: Offset 0x14 is the route register. A controller's normal output is the OR of status AND enable AND NOT route. Its fast output is the OR of status AND enable AND route.
- R9: The subordinate outputs drive the main lines listed in the cascade table. The external main inputs at those four positions are ignored.
- R10: Select 0, 1 and 2 address the main controller, sub 1 and sub 2. Select 3 reads 0 and its writes change nothing. Undefined offsets read 0.
- R11: After the acknowledge sequence (mask, then write-one-to-clear) and a later re-enable, the line stays quiet until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| main_lines_i | input | 32 | External request lines of the main controller (bits 0, 1, 30, 31 unused) |
| sub1_lines_i | input | 32 | Request lines of subordinate controller 1 |
| sub2_lines_i | input | 32 | Request lines of subordinate controller 2 |
| reg_sel_i | input | 2 | Controller select: 0 main, 1 sub 1, 2 sub 2 |
| reg_addr_i | input | 5 | Byte offset of the register |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
Several properties are checked on every cycle:

- the reset value of the enable registers;
- a fully masked controller keeps its outputs low;
- a latched edge bit is never lost unless its clear bit was written;
- a level-mode status bit always equals the previous cycle's corrected input;
- select 3 reads zero.

Other behaviours can only be shown by the bench's scenarios, which a reference model follows cycle by cycle:

- the exact two-stage synchronizer latency;
- the four-line cascade mapping;
- the acknowledge sequence;
- the type and polarity combinations under random register traffic.

// File: rtl/icc_pkg.sv
package icc_pkg;
    localparam int LINES = 32;
    localparam int AW    = 5;
    localparam int SELW  = 2;
    localparam int NCTL  = 3;

    localparam logic [AW-1:0] OFF_EN   = AW'(8'h00);
    localparam logic [AW-1:0] OFF_RAW  = AW'(8'h04);
    localparam logic [AW-1:0] OFF_ST   = AW'(8'h08);
    localparam logic [AW-1:0] OFF_POL  = AW'(8'h0C);
    localparam logic [AW-1:0] OFF_TYP  = AW'(8'h10);
    localparam logic [AW-1:0] OFF_ROUTE = AW'(8'h14);

    // cascade positions on the main controller
    localparam int POS_S1_IRQ = 0;
    localparam int POS_S2_IRQ = 1;
    localparam int POS_S2_FIQ = LINES - 2;
    localparam int POS_S1_FIQ = LINES - 1;

    localparam logic [LINES-1:0] CASC_MASK =
        (LINES'(1) << POS_S1_IRQ) | (LINES'(1) << POS_S2_IRQ) |
        (LINES'(1) << POS_S2_FIQ) | (LINES'(1) << POS_S1_FIQ);
    localparam logic [LINES-1:0] MAIN_ROUTE_INIT =
        (LINES'(1) << POS_S2_FIQ) | (LINES'(1) << POS_S1_FIQ);

    typedef struct packed {
        logic [LINES-1:0] en;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] typ;
        logic [LINES-1:0] route;
        logic [LINES-1:0] st;
        logic [LINES-1:0] prev;
    } ctl_state_t;

    typedef struct packed {
        logic [LINES-1:0] s1;
        logic [LINES-1:0] s2;
    } sync_state_t;
endpackage

// File: rtl/icc_sync.sv
module icc_sync
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] sync_o
);
    sync_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = async_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.s2;
endmodule

// File: rtl/icc_unit.sv
module icc_unit
    import icc_pkg::*;
#(
    parameter logic [LINES-1:0] EN_INIT    = '0,
    parameter logic [LINES-1:0] ROUTE_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LINES-1:0] wdata_i,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] rdata_o,
    output logic             irq_o,
    output logic             fiq_o,
    output logic [LINES-1:0] en_o,
    output logic [LINES-1:0] st_o,
    output logic [LINES-1:0] typ_o,
    output logic [LINES-1:0] raw_o
);
    ctl_state_t s_d, s_q;
    logic [LINES-1:0] corr, clr, edge_hit, live;

    always_comb begin
        s_d      = s_q;
        corr     = ~(line_i ^ s_q.pol);
        clr      = (wr_i && addr_i == OFF_ST) ? wdata_i : '0;
        edge_hit = corr & ~s_q.prev;
        s_d.st   = (s_q.typ & ((s_q.st & ~clr) | edge_hit)) | (~s_q.typ & corr);
        s_d.prev = corr;
        if (wr_i) begin
            case (addr_i)
                OFF_EN:    s_d.en    = wdata_i;
                OFF_POL:   s_d.pol   = wdata_i;
                OFF_TYP:   s_d.typ   = wdata_i;
                OFF_ROUTE: s_d.route = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.en    <= EN_INIT;
            s_q.pol   <= '1;
            s_q.route <= ROUTE_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (addr_i)
            OFF_EN:    rdata_o = s_q.en;
            OFF_RAW:   rdata_o = corr;
            OFF_ST:    rdata_o = s_q.st;
            OFF_POL:   rdata_o = s_q.pol;
            OFF_TYP:   rdata_o = s_q.typ;
            OFF_ROUTE: rdata_o = s_q.route;
            default:   rdata_o = '0;
        endcase
    end

    assign live  = s_q.st & s_q.en;
    assign irq_o = |(live & ~s_q.route);
    assign fiq_o = |(live & s_q.route);
    assign en_o  = s_q.en;
    assign st_o  = s_q.st;
    assign typ_o = s_q.typ;
    assign raw_o = corr;
endmodule

// File: rtl/icc_top.sv
module icc_top
    import icc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] main_lines_i,
    input  logic [LINES-1:0] sub1_lines_i,
    input  logic [LINES-1:0] sub2_lines_i,
    input  logic [SELW-1:0]  reg_sel_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [LINES-1:0] reg_wdata_i,
    output logic [LINES-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [LINES-1:0] ext_a  [NCTL];
    logic [LINES-1:0] sync_a [NCTL];
    logic [LINES-1:0] line_a [NCTL];
    logic [LINES-1:0] rd_a   [NCTL];
    logic [LINES-1:0] en_a   [NCTL];
    logic [LINES-1:0] st_a   [NCTL];
    logic [LINES-1:0] typ_a  [NCTL];
    logic [LINES-1:0] raw_a  [NCTL];
    logic [NCTL-1:0]  irq_a, fiq_a;
    logic [LINES-1:0] casc;

    assign ext_a[0] = main_lines_i;
    assign ext_a[1] = sub1_lines_i;
    assign ext_a[2] = sub2_lines_i;

    always_comb begin
        casc             = '0;
        casc[POS_S1_IRQ] = irq_a[1];
        casc[POS_S2_IRQ] = irq_a[2];
        casc[POS_S2_FIQ] = fiq_a[2];
        casc[POS_S1_FIQ] = fiq_a[1];
    end

    for (genvar k = 0; k < NCTL; k++) begin : g_ctl
        icc_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (ext_a[k]),
            .sync_o  (sync_a[k])
        );

        if (k == 0) begin : g_main_in
            assign line_a[k] = (casc & CASC_MASK) | (sync_a[k] & ~CASC_MASK);
        end else begin : g_sub_in
            assign line_a[k] = sync_a[k];
        end

        icc_unit #(
            .EN_INIT    ((k == 0) ? CASC_MASK : LINES'(0)),
            .ROUTE_INIT ((k == 0) ? MAIN_ROUTE_INIT : LINES'(0))
        ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (reg_wr_i && (reg_sel_i == SELW'(k))),
            .addr_i  (reg_addr_i),
            .wdata_i (reg_wdata_i),
            .line_i  (line_a[k]),
            .rdata_o (rd_a[k]),
            .irq_o   (irq_a[k]),
            .fiq_o   (fiq_a[k]),
            .en_o    (en_a[k]),
            .st_o    (st_a[k]),
            .typ_o   (typ_a[k]),
            .raw_o   (raw_a[k])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int k = 0; k < NCTL; k++) begin
            if (reg_sel_i == SELW'(k)) reg_rdata_o = rd_a[k];
        end
    end

    assign irq_o = irq_a[0];
    assign fiq_o = fiq_a[0];
endmodule

// File: rtl/icc_chk.sv
module icc_chk
    import icc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SELW-1:0]  reg_sel_i,
    input logic [AW-1:0]    reg_addr_i,
    input logic             reg_wr_i,
    input logic [LINES-1:0] reg_wdata_i,
    input logic [LINES-1:0] reg_rdata_o,
    input logic             irq_o,
    input logic             fiq_o,
    input logic [LINES-1:0] en_a  [NCTL],
    input logic [LINES-1:0] st_a  [NCTL],
    input logic [LINES-1:0] typ_a [NCTL],
    input logic [LINES-1:0] raw_a [NCTL],
    input logic [NCTL-1:0]  irq_a,
    input logic [NCTL-1:0]  fiq_a
);
    a_r1_reset_enables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_a[0] == 32'hC000_0003 && en_a[1] == '0 && en_a[2] == '0));

    a_r2_main_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a[0] == '0) |-> (!irq_o && !fiq_o));

    a_r8_out_needs_live_line: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (|(st_a[0] & en_a[0])));

    a_r10_sel3_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i == SELW'(3)) |-> (reg_rdata_o == '0));

    for (genvar k = 0; k < NCTL; k++) begin : g_chk
        logic [LINES-1:0] clr;
        assign clr = (reg_wr_i && reg_sel_i == SELW'(k) && reg_addr_i == OFF_ST) ? reg_wdata_i : '0;

        a_r4_edge_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (($past(st_a[k] & typ_a[k] & ~clr) & ~st_a[k]) == '0));

        a_r5_level_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((~$past(typ_a[k])) & (st_a[k] ^ $past(raw_a[k]))) == '0));

        if (k > 0) begin : g_sub
            a_r2_sub_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (en_a[k] == '0) |-> (!irq_a[k] && !fiq_a[k]));
        end
    end
endmodule

bind icc_top icc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel_i   (reg_sel_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .en_a        (en_a),
    .st_a        (st_a),
    .typ_a       (typ_a),
    .raw_a       (raw_a),
    .irq_a       (irq_a),
    .fiq_a       (fiq_a)
);

// File: tb/icc_top_test.sv
module icc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] main_lines = '0, sub1_lines = '0, sub2_lines = '0;
    logic [1:0]  reg_sel = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, fiq;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    icc_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_lines_i (main_lines),
        .sub1_lines_i (sub1_lines),
        .sub2_lines_i (sub2_lines),
        .reg_sel_i    (reg_sel),
        .reg_addr_i   (reg_addr),
        .reg_wr_i     (reg_wr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .irq_o        (irq),
        .fiq_o        (fiq)
    );

    // behavioural reference: index 0 main, 1 sub1, 2 sub2
    bit [31:0] m_en[3], m_pol[3], m_typ[3], m_rt[3], m_st[3], m_prev[3], m_s1[3], m_s2[3];

    function automatic bit m_irq(int k);
        return |(m_st[k] & m_en[k] & ~m_rt[k]);
    endfunction
    function automatic bit m_fiq(int k);
        return |(m_st[k] & m_en[k] & m_rt[k]);
    endfunction
    function automatic bit [31:0] m_line(int k);
        bit [31:0] v = m_s2[k];
        if (k == 0) begin
            v[0] = m_irq(1); v[1] = m_irq(2); v[30] = m_fiq(2); v[31] = m_fiq(1);
        end
        return v;
    endfunction
    function automatic bit [31:0] m_corr(int k);
        bit [31:0] l = m_line(k);
        bit [31:0] c;
        for (int b = 0; b < 32; b++) c[b] = m_pol[k][b] ? l[b] : !l[b];
        return c;
    endfunction
    function automatic bit [31:0] m_read(int sel, int addr);
        if (sel > 2) return 0;
        case (addr)
            'h00: return m_en[sel];
            'h04: return m_corr(sel);
            'h08: return m_st[sel];
            'h0C: return m_pol[sel];
            'h10: return m_typ[sel];
            'h14: return m_rt[sel];
            default: return 0;
        endcase
    endfunction

    task automatic m_reset();
        for (int k = 0; k < 3; k++) begin
            m_en[k] = 0; m_pol[k] = '1; m_typ[k] = 0; m_rt[k] = 0;
            m_st[k] = 0; m_prev[k] = 0; m_s1[k] = 0; m_s2[k] = 0;
        end
        m_en[0] = 32'hC000_0003;
        m_rt[0] = 32'hC000_0000;
    endtask

    task automatic m_step();
        bit [31:0] c[3];
        bit [31:0] ins[3];
        ins[0] = main_lines; ins[1] = sub1_lines; ins[2] = sub2_lines;
        for (int k = 0; k < 3; k++) c[k] = m_corr(k);
        for (int k = 0; k < 3; k++) begin
            bit wr_here = reg_wr && (int'(reg_sel) == k);
            for (int b = 0; b < 32; b++) begin
                if (m_typ[k][b]) begin
                    if (wr_here && reg_addr == 5'h08 && reg_wdata[b]) m_st[k][b] = 0;
                    if (c[k][b] && !m_prev[k][b]) m_st[k][b] = 1;
                end else begin
                    m_st[k][b] = c[k][b];
                end
            end
            m_prev[k] = c[k];
            m_s2[k] = m_s1[k];
            m_s1[k] = ins[k];
            if (wr_here) begin
                case (reg_addr)
                    5'h00: m_en[k]  = reg_wdata;
                    5'h0C: m_pol[k] = reg_wdata;
                    5'h10: m_typ[k] = reg_wdata;
                    5'h14: m_rt[k]  = reg_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag(int sel, int addr);
        if (sel > 2) return "R10 select 3";
        case (addr)
            'h00: return "R2 enable";
            'h04: return "R6 raw";
            'h08: return "R4 status";
            'h0C, 'h10: return "R3 type/polarity";
            'h14: return "R8 route";
            default: return "R10 undefined offset";
        endcase
    endfunction

    task automatic compare();
        check(rd_tag(reg_sel, reg_addr), reg_rdata, m_read(reg_sel, reg_addr));
        check("R8 R9 irq_o", {31'b0, irq}, {31'b0, m_irq(0)});
        check("R8 R9 fiq_o", {31'b0, fiq}, {31'b0, m_fiq(0)});
    endtask

    task automatic tick();
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(int sel, int addr, logic [31:0] d);
        reg_sel = 2'(sel); reg_addr = 5'(addr); reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(int sel, int addr, logic [31:0] exp, string tag);
        reg_sel = 2'(sel); reg_addr = 5'(addr);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic out_chk(bit ei, bit ef, string tag);
        check({tag, " irq_o"}, {31'b0, irq}, {31'b0, ei});
        check({tag, " fiq_o"}, {31'b0, fiq}, {31'b0, ef});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(0, 'h00, 32'hC000_0003, "R1 main enable");
        rd_chk(1, 'h00, 32'h0, "R1 sub1 enable");
        rd_chk(2, 'h00, 32'h0, "R1 sub2 enable");
        rd_chk(1, 'h08, 32'h0, "R1 sub1 status");
        rd_chk(0, 'h0C, 32'hFFFF_FFFF, "R1 main polarity");
        rd_chk(0, 'h14, 32'hC000_0000, "R1 main route");
        out_chk(0, 0, "R1");

        // R2 enable readback
        wr(1, 'h00, 32'h20);
        rd_chk(1, 'h00, 32'h20, "R2 sub1 enable");

        // R3/R7 rising edge on sub1 line 5
        wr(1, 'h10, 32'h20);
        sub1_lines[5] = 1'b1;
        ticks(2);
        rd_chk(1, 'h04, 32'h20, "R7 raw after two edges");
        rd_chk(1, 'h08, 32'h0, "R7 status not yet");
        tick();
        rd_chk(1, 'h08, 32'h20, "R3 edge latched");
        out_chk(0, 0, "R9 before main stage");
        tick();
        out_chk(1, 0, "R9 sub1 irq to main line 0");
        sub1_lines[5] = 1'b0;
        ticks(4);
        rd_chk(1, 'h08, 32'h20, "R3 edge held after input falls");

        // R4 write-one-to-clear
        wr(1, 'h08, 32'h0);
        rd_chk(1, 'h08, 32'h20, "R4 zero write no effect");
        wr(1, 'h08, 32'h20);
        rd_chk(1, 'h08, 32'h0, "R4 one clears");
        tick();
        out_chk(0, 0, "R4 output drops");

        // R11 acknowledge sequence
        sub1_lines[5] = 1'b1;
        ticks(4);
        out_chk(1, 0, "R11 pending");
        sub1_lines[5] = 1'b0;
        wr(1, 'h00, 32'h0);
        tick();
        out_chk(0, 0, "R11 masked");
        wr(1, 'h08, 32'h20);
        wr(1, 'h00, 32'h20);
        ticks(2);
        rd_chk(1, 'h08, 32'h0, "R11 status cleared");
        out_chk(0, 0, "R11 quiet after re-enable");

        // R5/R6 level-low on sub2 line 7, masked
        wr(2, 'h0C, 32'hFFFF_FF7F);
        rd_chk(2, 'h04, 32'h80, "R6 raw visible while masked");
        tick();
        rd_chk(2, 'h08, 32'h80, "R5 low level active");
        wr(2, 'h08, 32'h80);
        rd_chk(2, 'h08, 32'h80, "R5 clear ignored in level mode");
        sub2_lines[7] = 1'b1;
        ticks(3);
        rd_chk(2, 'h08, 32'h0, "R5 follows input high");
        sub2_lines[7] = 1'b0;
        ticks(3);
        rd_chk(2, 'h08, 32'h80, "R5 follows input low");

        // R8 route to fast output via main line 30
        wr(2, 'h14, 32'h80);
        wr(2, 'h00, 32'h80);
        tick();
        out_chk(0, 1, "R8 sub2 fast path");
        rd_chk(0, 'h04, 32'h4000_0000, "R9 main raw shows sub2 fast");

        // R9 external main bits at cascade positions ignored
        main_lines = 32'hFFFF_FFFF;
        ticks(3);
        rd_chk(0, 'h04, 32'h7FFF_FFFC, "R9 external cascade bits ignored");
        out_chk(0, 1, "R2 other main lines masked");
        main_lines = 32'h0;

        // R10 select 3 and undefined offsets
        rd_chk(3, 'h00, 32'h0, "R10 select 3 read");
        wr(3, 'h00, 32'hFFFF_FFFF);
        rd_chk(0, 'h00, 32'hC000_0003, "R10 select 3 write main");
        rd_chk(1, 'h00, 32'h20, "R10 select 3 write sub1");
        rd_chk(2, 'h00, 32'h80, "R10 select 3 write sub2");
        rd_chk(1, 'h18, 32'h0, "R10 undefined offset");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            main_lines ^= $urandom & $urandom & $urandom;
            sub1_lines ^= $urandom & $urandom & $urandom;
            sub2_lines ^= $urandom & $urandom & $urandom;
            reg_sel   = 2'($urandom_range(0, 3));
            reg_addr  = 5'($urandom_range(0, 7) * 4);
            reg_wdata = $urandom;
            reg_wr    = ($urandom_range(0, 5) == 0);
            if (reg_wr && reg_addr == 5'h00 && $urandom_range(0, 1) == 1) reg_wdata = '1;
            tick();
            reg_wr = 1'b0;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule